// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block carries bytes between a host processor and a peripheral controller through a single 8-bit shift-data register. The host drives three active-low handshake lines kept in a port-B register: transfer-in-progress and acknowledge are written by the host, and request is driven only by the block. A direction bit in a control register picks whether bytes flow from host to device or from device to host.

A byte moves when the host writes port-B and the in-progress/acknowledge pair changes state. No clock-edge shifting is involved. Host-to-device bytes are collected in a 16-entry packet buffer. When in-progress is released, the block reports the completed packet with a one-cycle pulse and its byte count, and the bytes can be read back through a read port. Device-to-host bytes come from a 128-entry response buffer that is filled through a load port and armed by a commit strobe with a length. Every completed handshake step sets a shift-register flag that the host clears. While no transfer is running, the request line either mirrors acknowledge (synchronisation toggles) or announces pending response data.

Top module: `hs_xfer_engine`

## Requirements
- R1: After synchronous reset, portb_q, sd_q, sd_flag, pkt_valid and pkt_len are all zero.
- R2: A port-B write updates every bit of portb_q on the next clock except bit 3 (request), which the written value never changes. portb_q is stable when there is no port-B write, control write or commit.
- R3: With control bit 4 = 1 (host to device) and bit 5 of port-B low (in progress), a port-B write whose {bit 5, bit 4} differs from the stored value appends sd_q to the outbound buffer and sets sd_flag. A write with an unchanged pair stores nothing.
- R4: Once 16 outbound bytes are held, further changes store nothing and do not set sd_flag. The packet count stays 16.
- R5: With control bit 4 = 0 and bit 5 low, each pair change loads the next unread response byte into sd_q and sets sd_flag. Consuming the last byte drives bit 3 high. Once the buffer is exhausted, changes have no effect.
- R6: When bit 5 is high both before and after a port-B write and bit 4 toggles, bit 3 takes the new bit 4 value and sd_flag is set.
- R7: When bit 5 goes from low to high, sd_flag is set. If outbound bytes are held, pkt_valid pulses for one cycle with pkt_len equal to their count, ob_rdata at addresses 0..count-1 returns them in order, and the count restarts at zero.
- R8: When bit 5 is high, was high, and bit 4 did not toggle, bit 3 is driven low if unread response bytes remain. This is evaluated on port-B writes, control writes and commits.
- R9: rsp_commit sets the readable length to rsp_len, capped at 128, and restarts the read position at 0. It sets sd_flag and re-evaluates the handshake state in the same cycle.
- R10: sd_flag_clr clears sd_flag on the next clock unless a flag-setting event occurs in the same cycle, in which case the flag stays set.
- R11: An sd_wr loads sd_wdata into sd_q on the next clock unless a response byte is loaded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| portb_wr | input | 1 | Port-B write strobe |
| portb_wdata | input | 8 | Port-B write value (bit 5 in progress, bit 4 acknowledge, active low) |
| portb_q | output | 8 | Port-B register; bit 3 is the request line driven by the block |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control value; bit 4 = 1 host to device |
| sd_wr | input | 1 | Shift-data write strobe |
| sd_wdata | input | 8 | Shift-data write value |
| sd_q | output | 8 | Shift-data register |
| sd_flag | output | 1 | Shift-register interrupt flag |
| sd_flag_clr | input | 1 | Clear strobe for sd_flag |
| rsp_wr | input | 1 | Response buffer write strobe |
| rsp_waddr | input | 7 | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |
| rsp_commit | input | 1 | Arm response with length rsp_len |
| rsp_len | input | 8 | Response length, capped at 128 |
| ob_raddr | input | 4 | Outbound buffer read address |
| ob_rdata | output | 8 | Outbound buffer read data (combinational) |
| pkt_valid | output | 1 | One-cycle packet-complete pulse |
| pkt_len | output | 5 | Byte count during pkt_valid, zero otherwise |

## Verification
A wrong index or count shows up at the ports on the very next clock. A bad read position puts the wrong byte in sd_q, a bad outbound count gives the wrong pkt_len or buffer contents at the end of the packet, and bad edge detection sets sd_flag or moves bit 3 of portb_q one cycle after a write that should have done nothing. Because a reference model is compared on every clock, a divergence is reported in the cycle it first reaches any output. Stored-but-unreported state is exposed at the next in-progress release.

// File: rtl/hs_xfer_pkg.sv
// Package: bit positions of the handshake and direction fields.
// Assumes the port-B and control registers are at least 6 bits wide.
package hs_xfer_pkg;
    localparam int REQ_BIT = 3;   // request, driven by the block, active low
    localparam int ACK_BIT = 4;   // acknowledge from host, active low
    localparam int TIP_BIT = 5;   // transfer in progress from host, active low
    localparam int DIR_BIT = 4;   // control: 1 = host to device
endpackage

// File: rtl/hs_out_buf.sv
// Outbound packet buffer: appends bytes while not full, flushes the
// count at end of packet, and offers a combinational read port.
// Assumes DEPTH is a power of two; push and flush never coincide.
module hs_out_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       flush,
    input  logic [DW-1:0]              din,
    input  logic [$clog2(DEPTH)-1:0]   raddr,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH):0]     cnt,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];

    assign full  = (cnt == CW'(DEPTH));
    assign rdata = mem[raddr];

    // Count of bytes held in the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (flush)            cnt <= '0;
        else if (push && !full)    cnt <= cnt + 1'b1;
    end

    // Byte storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !full) begin
            mem[cnt[AW-1:0]] <= din;
        end
    end
endmodule

// File: rtl/hs_rsp_buf.sv
// Response buffer: written through a load port, armed by a commit with
// a clamped length, read sequentially by pop. Status outputs already
// account for a commit in the same cycle.
// Assumes DEPTH is a power of two and no write hits entry 0 while committing.
module hs_rsp_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [$clog2(DEPTH)-1:0]   waddr,
    input  logic [DW-1:0]              wdata,
    input  logic                       commit,
    input  logic [$clog2(DEPTH):0]     len_in,
    input  logic                       pop,
    output logic                       avail,
    output logic                       last,
    output logic [DW-1:0]              byte_q
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [LW-1:0] idx, len, len_cl, eff_idx, eff_len;
    logic [LW:0]   idx_inc;

    // Effective read position and length, after any same-cycle commit.
    always_comb begin
        len_cl  = (len_in > LW'(DEPTH)) ? LW'(DEPTH) : len_in;
        eff_idx = commit ? '0 : idx;
        eff_len = commit ? len_cl : len;
        idx_inc = {1'b0, eff_idx} + 1'b1;
        avail   = (eff_idx < eff_len);
        last    = (idx_inc >= {1'b0, eff_len});
        byte_q  = mem[eff_idx[AW-1:0]];
    end

    // Read position and armed length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            len <= '0;
        end else begin
            if (commit) len <= len_cl;
            if (pop)    idx <= idx_inc[LW-1:0];
            else        idx <= eff_idx;
        end
    end

    // Response byte storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/hs_hs_ctrl.sv
// Handshake controller: merges same-cycle register writes into effective
// values, compares them with the stored port-B copy (which serves as the
// previous value), and decides push, pop, flush, request level and flag.
// Assumes buffer status inputs already reflect a same-cycle commit.
module hs_hs_ctrl
    import hs_xfer_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          portb_wr,
    input  logic [DW-1:0] portb_wdata,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] ctrl_wdata,
    input  logic          sd_wr,
    input  logic [DW-1:0] sd_wdata,
    input  logic          flag_clr,
    input  logic          commit,
    input  logic          ob_full,
    input  logic [CW-1:0] ob_cnt,
    input  logic          rsp_avail,
    input  logic          rsp_last,
    input  logic [DW-1:0] rsp_byte,
    output logic [DW-1:0] portb_q,
    output logic [DW-1:0] sd_q,
    output logic          sd_flag,
    output logic          ob_push,
    output logic          ob_flush,
    output logic          rsp_pop,
    output logic [DW-1:0] push_data,
    output logic          pkt_valid,
    output logic [CW-1:0] pkt_len
);
    logic          dir_q;
    logic [DW-1:0] eff_b, b_nxt, sd_nxt;
    logic          eff_dir, eval_en, pair_chg, set_flag;

    // Decide this cycle's handshake action from effective and stored values.
    always_comb begin
        eff_b = portb_q;
        if (portb_wr) begin
            eff_b          = portb_wdata;
            eff_b[REQ_BIT] = portb_q[REQ_BIT];
        end
        eff_dir   = ctrl_wr ? ctrl_wdata[DIR_BIT] : dir_q;
        sd_nxt    = sd_wr ? sd_wdata : sd_q;
        push_data = sd_nxt;
        eval_en   = portb_wr | ctrl_wr | commit;
        pair_chg  = (eff_b[TIP_BIT] != portb_q[TIP_BIT]) ||
                    (eff_b[ACK_BIT] != portb_q[ACK_BIT]);
        b_nxt     = eff_b;
        set_flag  = commit;
        ob_push   = 1'b0;
        ob_flush  = 1'b0;
        rsp_pop   = 1'b0;
        if (eval_en) begin
            if (!eff_b[TIP_BIT]) begin
                if (eff_dir) begin
                    if (pair_chg && !ob_full) begin
                        ob_push  = 1'b1;
                        set_flag = 1'b1;
                    end
                end else if (pair_chg && rsp_avail) begin
                    rsp_pop  = 1'b1;
                    sd_nxt   = rsp_byte;
                    set_flag = 1'b1;
                    if (rsp_last) b_nxt[REQ_BIT] = 1'b1;
                end
            end else if (portb_q[TIP_BIT] &&
                         (eff_b[ACK_BIT] != portb_q[ACK_BIT])) begin
                b_nxt[REQ_BIT] = eff_b[ACK_BIT];
                set_flag       = 1'b1;
            end else begin
                if (!portb_q[TIP_BIT]) begin
                    set_flag = 1'b1;
                    ob_flush = (ob_cnt != '0);
                end
                if (rsp_avail) b_nxt[REQ_BIT] = 1'b0;
            end
        end
    end

    // Registered port-B, direction and shift data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            portb_q <= '0;
            dir_q   <= 1'b0;
            sd_q    <= '0;
        end else begin
            portb_q <= b_nxt;
            dir_q   <= eff_dir;
            sd_q    <= sd_nxt;
        end
    end

    // Flag with set priority, and the packet-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_flag   <= 1'b0;
            pkt_valid <= 1'b0;
            pkt_len   <= '0;
        end else begin
            sd_flag   <= (sd_flag & ~flag_clr) | set_flag;
            pkt_valid <= ob_flush;
            pkt_len   <= ob_flush ? ob_cnt : '0;
        end
    end
endmodule

// File: rtl/hs_xfer_engine.sv
// Top: handshaked byte transfer engine. Connects the handshake controller
// to the outbound packet buffer and the response buffer.
// Assumes DATA_W >= 6 and power-of-two buffer depths.
module hs_xfer_engine #(
    parameter int DATA_W    = 8,
    parameter int OB_DEPTH  = 16,
    parameter int RSP_DEPTH = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          portb_wr,
    input  logic [DATA_W-1:0]             portb_wdata,
    output logic [DATA_W-1:0]             portb_q,
    input  logic                          ctrl_wr,
    input  logic [DATA_W-1:0]             ctrl_wdata,
    input  logic                          sd_wr,
    input  logic [DATA_W-1:0]             sd_wdata,
    output logic [DATA_W-1:0]             sd_q,
    output logic                          sd_flag,
    input  logic                          sd_flag_clr,
    input  logic                          rsp_wr,
    input  logic [$clog2(RSP_DEPTH)-1:0]  rsp_waddr,
    input  logic [DATA_W-1:0]             rsp_wdata,
    input  logic                          rsp_commit,
    input  logic [$clog2(RSP_DEPTH):0]    rsp_len,
    input  logic [$clog2(OB_DEPTH)-1:0]   ob_raddr,
    output logic [DATA_W-1:0]             ob_rdata,
    output logic                          pkt_valid,
    output logic [$clog2(OB_DEPTH):0]     pkt_len
);
    localparam int OCW = $clog2(OB_DEPTH) + 1;

    logic              ob_push, ob_flush, ob_full, rsp_pop, rsp_avail, rsp_last;
    logic [OCW-1:0]    ob_cnt;
    logic [DATA_W-1:0] rsp_byte, push_data;

    hs_hs_ctrl #(.DW(DATA_W), .CW(OCW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .portb_wr(portb_wr), .portb_wdata(portb_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .sd_wr(sd_wr), .sd_wdata(sd_wdata),
        .flag_clr(sd_flag_clr), .commit(rsp_commit),
        .ob_full(ob_full), .ob_cnt(ob_cnt),
        .rsp_avail(rsp_avail), .rsp_last(rsp_last), .rsp_byte(rsp_byte),
        .portb_q(portb_q), .sd_q(sd_q), .sd_flag(sd_flag),
        .ob_push(ob_push), .ob_flush(ob_flush), .rsp_pop(rsp_pop),
        .push_data(push_data), .pkt_valid(pkt_valid), .pkt_len(pkt_len)
    );

    hs_out_buf #(.DW(DATA_W), .DEPTH(OB_DEPTH)) u_obuf (
        .clk(clk), .rst_n(rst_n),
        .push(ob_push), .flush(ob_flush), .din(push_data),
        .raddr(ob_raddr), .rdata(ob_rdata),
        .cnt(ob_cnt), .full(ob_full)
    );

    hs_rsp_buf #(.DW(DATA_W), .DEPTH(RSP_DEPTH)) u_rbuf (
        .clk(clk), .rst_n(rst_n),
        .wr(rsp_wr), .waddr(rsp_waddr), .wdata(rsp_wdata),
        .commit(rsp_commit), .len_in(rsp_len), .pop(rsp_pop),
        .avail(rsp_avail), .last(rsp_last), .byte_q(rsp_byte)
    );
endmodule

// File: rtl/hs_xfer_engine_chk.sv
// Checker for hs_xfer_engine: port-level temporal properties, bound below.
module hs_xfer_engine_chk #(
    parameter int DATA_W   = 8,
    parameter int OB_DEPTH = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      portb_wr,
    input logic [DATA_W-1:0]         portb_wdata,
    input logic [DATA_W-1:0]         portb_q,
    input logic                      ctrl_wr,
    input logic                      sd_wr,
    input logic [DATA_W-1:0]         sd_wdata,
    input logic [DATA_W-1:0]         sd_q,
    input logic                      sd_flag,
    input logic                      sd_flag_clr,
    input logic                      rsp_commit,
    input logic                      pkt_valid,
    input logic [$clog2(OB_DEPTH):0] pkt_len
);
    logic any_eval;
    logic [DATA_W-1:0] req_mask;
    assign any_eval = portb_wr | ctrl_wr | rsp_commit;
    assign req_mask = ~(DATA_W'(1) << 3);

    assert_pkt_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != 0) && (pkt_len <= OB_DEPTH));
    assert_pkt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);
    assert_pkt_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> sd_flag);
    assert_portb_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        portb_wr |=> ((portb_q & req_mask) == ($past(portb_wdata) & req_mask)));
    assert_portb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_eval |=> $stable(portb_q));
    assert_sd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_eval || sd_wr) |=> $stable(sd_q));
    assert_sd_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_wr && !any_eval) |=> (sd_q == $past(sd_wdata)));
    assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_flag) |-> $past(any_eval));
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_flag_clr && !any_eval) |=> !sd_flag);
endmodule

bind hs_xfer_engine hs_xfer_engine_chk #(.DATA_W(DATA_W), .OB_DEPTH(OB_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .portb_wr(portb_wr), .portb_wdata(portb_wdata),
    .portb_q(portb_q), .ctrl_wr(ctrl_wr), .sd_wr(sd_wr), .sd_wdata(sd_wdata),
    .sd_q(sd_q), .sd_flag(sd_flag), .sd_flag_clr(sd_flag_clr),
    .rsp_commit(rsp_commit), .pkt_valid(pkt_valid), .pkt_len(pkt_len)
);

// File: tb/hs_xfer_engine_test.sv
module hs_xfer_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic portb_wr = 0, ctrl_wr = 0, sd_wr = 0, sd_flag_clr = 0;
    logic rsp_wr = 0, rsp_commit = 0;
    logic [7:0] portb_wdata = 0, ctrl_wdata = 0, sd_wdata = 0, rsp_wdata = 0;
    logic [6:0] rsp_waddr = 0;
    logic [7:0] rsp_len = 0;
    logic [3:0] ob_raddr = 0;
    logic [7:0] portb_q, sd_q, ob_rdata;
    logic       sd_flag, pkt_valid;
    logic [4:0] pkt_len;

    always #5 clk = ~clk;

    hs_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .portb_wr(portb_wr), .portb_wdata(portb_wdata),
        .portb_q(portb_q), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .sd_wr(sd_wr), .sd_wdata(sd_wdata), .sd_q(sd_q), .sd_flag(sd_flag),
        .sd_flag_clr(sd_flag_clr), .rsp_wr(rsp_wr), .rsp_waddr(rsp_waddr),
        .rsp_wdata(rsp_wdata), .rsp_commit(rsp_commit), .rsp_len(rsp_len),
        .ob_raddr(ob_raddr), .ob_rdata(ob_rdata), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len)
    );

    int tests = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // Behavioural reference model state.
    bit [7:0] m_b = 0, m_sd = 0;
    bit       m_dir = 0, m_flag = 0, m_pv = 0;
    int       m_pl = 0, m_idx = 0, m_len = 0;
    bit [7:0] m_rsp [128];
    bit [7:0] m_ob [$];
    bit [7:0] m_pkt [$];

    task automatic check(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit [7:0] nb; bit nd; bit [7:0] nsd; bit st;
        m_pv = 0; m_pl = 0;
        nb = m_b;
        if (portb_wr) begin nb = portb_wdata; nb[3] = m_b[3]; end
        nd  = ctrl_wr ? ctrl_wdata[4] : m_dir;
        nsd = sd_wr ? sd_wdata : m_sd;
        st  = rsp_commit;
        if (rsp_commit) begin m_idx = 0; m_len = (rsp_len > 128) ? 128 : int'(rsp_len); end
        if (portb_wr || ctrl_wr || rsp_commit) begin
            if (nb[5] == 0) begin
                if ({nb[5], nb[4]} != {m_b[5], m_b[4]}) begin
                    if (nd) begin
                        if (m_ob.size() < 16) begin m_ob.push_back(nsd); st = 1; end
                    end else if (m_idx < m_len) begin
                        nsd = m_rsp[m_idx]; m_idx++; st = 1;
                        if (m_idx >= m_len) nb[3] = 1;
                    end
                end
            end else if (m_b[5] == 1 && nb[4] != m_b[4]) begin
                nb[3] = nb[4]; st = 1;
            end else begin
                if (m_b[5] == 0) begin
                    st = 1;
                    if (m_ob.size() > 0) begin
                        m_pv = 1; m_pl = m_ob.size(); m_pkt = m_ob; m_ob.delete();
                    end
                end
                if (m_idx < m_len) nb[3] = 0;
            end
        end
        m_flag = (m_flag && !sd_flag_clr) || st;
        if (rsp_wr) m_rsp[rsp_waddr] = rsp_wdata;
        m_b = nb; m_dir = nd; m_sd = nsd;
    endtask

    task automatic compare();
        check(cur_req, portb_q, m_b, "portb_q");
        check(cur_req, sd_q, m_sd, "sd_q");
        check(cur_req, sd_flag, m_flag, "sd_flag");
        check(cur_req, pkt_valid, m_pv, "pkt_valid");
        check(cur_req, pkt_len, m_pl, "pkt_len");
    endtask

    // One clock: model the applied inputs, clock, compare, release strobes.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        portb_wr = 0; ctrl_wr = 0; sd_wr = 0; sd_flag_clr = 0;
        rsp_wr = 0; rsp_commit = 0;
    endtask

    task automatic pb(bit [7:0] v);  portb_wr = 1; portb_wdata = v; step(); endtask
    task automatic ctl(bit [7:0] v); ctrl_wr = 1; ctrl_wdata = v; step(); endtask
    task automatic sdw(bit [7:0] v); sd_wr = 1; sd_wdata = v; step(); endtask
    task automatic clr();            sd_flag_clr = 1; step(); endtask
    task automatic commit(bit [7:0] n); rsp_commit = 1; rsp_len = n; step(); endtask

    task automatic check_pkt(string req);
        foreach (m_pkt[i]) begin
            ob_raddr = 4'(i);
            #1;
            check(req, ob_rdata, m_pkt[i], "ob_rdata");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", portb_q, 0, "portb_q");
        check("R1", sd_q, 0, "sd_q");
        check("R1", {sd_flag, pkt_valid, pkt_len}, 0, "flag/pkt");

        // R2: write all ones; bit 3 must stay low
        cur_req = "R2";
        pb(8'hFF);
        check("R2", portb_q, 8'hF7, "portb bit3 ignored");
        clr();
        check("R10", sd_flag, 0, "flag cleared");

        // R6: idle sync, request mirrors acknowledge
        cur_req = "R6";
        pb(8'hE7);
        check("R6", portb_q[3], 0, "req follows ack low");
        pb(8'hF7);
        check("R6", portb_q[3], 1, "req follows ack high");
        check("R6", sd_flag, 1, "flag on ack toggle");
        clr();

        // R11: shift data write
        cur_req = "R11";
        sdw(8'h5C);
        check("R11", sd_q, 8'h5C, "sd_q loaded");

        // R3 / R7: outbound packet of three bytes
        cur_req = "R3";
        ctl(8'h10);
        sdw(8'hA1); pb(8'h10);
        sdw(8'hB2); pb(8'h00);
        clr();
        pb(8'h00);
        check("R3", sd_flag, 0, "unchanged pair stores nothing");
        sdw(8'hC3); pb(8'h10);
        cur_req = "R7";
        pb(8'h30);
        check("R7", pkt_valid, 1, "pkt pulse");
        check("R7", pkt_len, 3, "pkt length");
        check_pkt("R7");
        clr();

        // R4: overflow, 20 toggles keep 16
        cur_req = "R4";
        for (int i = 0; i < 20; i++) begin
            sdw(8'(8'h40 + i));
            pb((i % 2 == 0) ? 8'h00 : 8'h10);
        end
        clr();
        pb(8'h10);
        check("R4", sd_flag, 0, "full buffer sets no flag");
        pb(8'h30);
        check("R4", pkt_len, 16, "count capped");
        check_pkt("R4");

        // R9 / R8 / R5: response of five bytes
        cur_req = "R9";
        ctl(8'h00);
        for (int i = 0; i < 5; i++) begin
            rsp_wr = 1; rsp_waddr = 7'(i); rsp_wdata = 8'(8'h90 + i); step();
        end
        clr();
        commit(8'd5);
        check("R9", sd_flag, 1, "commit sets flag");
        check("R8", portb_q[3], 0, "req asserted with pending data");
        cur_req = "R5";
        for (int i = 0; i < 5; i++) begin
            pb((i % 2 == 0) ? 8'h00 : 8'h10);
            check("R5", sd_q, 8'h90 + i, "inbound byte");
        end
        check("R5", portb_q[3], 1, "req released after last");
        sdw(8'h11);
        pb(8'h10);
        check("R5", sd_q, 8'h11, "exhausted buffer no load");
        pb(8'h30);

        // R9: length clamp to 128
        cur_req = "R9";
        for (int i = 0; i < 128; i++) begin
            rsp_wr = 1; rsp_waddr = 7'(i); rsp_wdata = 8'(i ^ 8'h5A); step();
        end
        commit(8'd200);
        for (int i = 0; i < 128; i++) begin
            pb((i % 2 == 0) ? 8'h00 : 8'h10);
            if (i == 126) check("R9", portb_q[3], 0, "req held before last");
        end
        check("R9", portb_q[3], 1, "req released at 128");
        check("R9", sd_q, 8'd127 ^ 8'h5A, "last byte");
        pb(8'h10);
        check("R9", sd_q, 8'd127 ^ 8'h5A, "no 129th byte");

        // R10: set wins over clear
        cur_req = "R10";
        pb(8'h30);
        sd_flag_clr = 1; portb_wr = 1; portb_wdata = 8'h20; step();
        check("R10", sd_flag, 1, "set beats clear");

        // Mixed traffic against the model
        cur_req = "R3/R5/R6/R7/R8";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 40) begin
                portb_wr = 1;
                portb_wdata = 8'($urandom_range(0, 255) & 8'hC7) | 8'($urandom_range(0, 3) << 4);
            end
            if ($urandom_range(0, 19) == 0) begin ctrl_wr = 1; ctrl_wdata = 8'($urandom_range(0, 255)); end
            if ($urandom_range(0, 3) == 0)  begin sd_wr = 1; sd_wdata = 8'($urandom_range(0, 255)); end
            if ($urandom_range(0, 5) == 0)  sd_flag_clr = 1;
            if ($urandom_range(0, 3) == 0)  begin
                rsp_wr = 1; rsp_waddr = 7'($urandom_range(1, 127)); rsp_wdata = 8'($urandom_range(0, 255));
            end
            if ($urandom_range(0, 39) == 0) begin rsp_commit = 1; rsp_len = 8'($urandom_range(0, 200)); end
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule